// File: doc/BRIEF.md
# Low-Power Real-Time Counter

This block keeps a 32-bit tick counter that advances from a slow 32768 Hz timebase, and compares it with a 32-bit alarm value. The slow timebase reaches the block as a single-cycle enable pulse, `slow_ce`, that has already been brought into the bus clock. A prescaler divides these pulses by its reload value plus one to form the counter tick. A reload of 0x7FFF gives one tick per second. A reload of 1 gives 16384 ticks per second.

Software sees eight 16-bit registers. Counter, alarm and prescaler values are written into staging copies. This is allowed only while a configuration window is open. Closing the window starts a transfer into the slow domain. A write-off status bit stays low while that transfer runs. The transfer lasts three slow pulses, and all staged groups are applied together on the third pulse. After each slow pulse, a bus-side shadow of the counter is refreshed and a synchronised flag is set. The counter wrapping to zero sets an overflow flag, and the counter reaching the alarm sets an alarm flag. Each flag can be routed to `irq`.

The transfer controller is a three-state machine. In IDLE the window is closed and write-off reads 1. A write of the configuration bit as 1 takes the ENTER transition into CONFIG. In CONFIG the staging copies accept writes, and entry loads them from the live values. A write of the configuration bit as 0 takes the COMMIT transition into XFER. In XFER write-off reads 0. The third slow pulse takes the DONE transition back to IDLE and applies the staged groups.

Top module: `rtc_lp_top`

Register word addresses (`bus_addr`):
- 0: status/control.
- 1: interrupt enables.
- 2: prescaler upper bits.
- 3: prescaler low 16 bits.
- 4: counter high half.
- 5: counter low half.
- 6: alarm high half.
- 7: alarm low half.

Status/control bits (address 0):
- bit0: alarm flag.
- bit1: overflow flag.
- bit2: synchronised flag.
- bit3: configuration bit.
- bit4: write-off (read-only).

Interrupt-enable bits (address 1):
- bit0: alarm interrupt enable.
- bit1: overflow interrupt enable.

## Requirements
- R1: After reset the block is in this state:
  - status reads 0x0010: write-off 1, every other bit 0;
  - the interrupt-enable register reads 0 and `irq` is 0;
  - the counter reads 0;
  - the alarm is all ones;
  - the prescaler reload is 0x7FFF.
- R2: With prescaler reload r, the counter advances by exactly one on every (r+1)-th slow pulse, counted from the pulse that applied the reload. After n further pulses it has advanced by floor(n/(r+1)).
- R3: Writes to the counter, alarm or prescaler registers (addresses 2 to 7) made outside the configuration window have no effect, now or at a later commit.
- R4: After COMMIT, write-off (status bit4) reads 0 through the first two slow pulses, and the counter keeps its old value. The third pulse applies the staged values and write-off returns to 1.
- R5: Each 32-bit value is applied as one unit. A half not written in the window keeps its live value. A group not written at all, such as the prescaler, keeps its value.
- R6: The synchronised flag (bit2) is set after each slow pulse, when the counter shadow is refreshed. A status write with bit2 = 0 clears it. A write with bit2 = 1 leaves it unchanged.
- R7: The overflow flag (bit1) is set when a tick moves the counter from 0xFFFFFFFF to 0.
- R8: The alarm flag (bit0) is set when a tick moves the counter to the alarm value. `irq` is high when (bit0 and alarm enable) or (bit1 and overflow enable).
- R9: A status write with bit0 or bit1 = 0 clears that flag. A write of 1 to either bit leaves it unchanged.
- R10: An alarm value of 0xFFFFFFFF never sets the alarm flag, even when the counter passes through that value.
- R11: A write of the configuration bit as 1 while write-off reads 0 is ignored, and the configuration bit keeps reading 0.
- R12: Prescaler and alarm registers are write-only and read 0. A read of counter low, then high, then low again, with no slow pulse in between, returns one coherent 32-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_ce | input | 1 | One-cycle pulse per slow-clock period |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq | output | 1 | Enabled flag interrupt |

## Verification
The bench sweeps prescaler reloads 0 to 3 and computes each expected count as floor(n/(r+1)). An off-by-one divider would show a count one step fast or slow. Overflow and alarm are checked on every pulse across the wrap from 0xFFFFFFFC, so a flag raised a tick early or late, or on the wrong compare, is caught at once. The transfer is probed mid-flight: a design that applied values early, let a re-entry slip into XFER, or leaked ignored or half-written values into the commit would show a wrong count or wrong status bits. An all-ones alarm is driven straight through the counter wrap, to catch a compare that is not suppressed.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int BUS_W = 16;
    localparam int CNT_W = 32;

    typedef enum logic [2:0] {
        RA_STAT    = 3'd0,
        RA_IE      = 3'd1,
        RA_PRE_UP  = 3'd2,
        RA_PRE_LO  = 3'd3,
        RA_CNT_UP  = 3'd4,
        RA_CNT_LO  = 3'd5,
        RA_ALM_UP  = 3'd6,
        RA_ALM_LO  = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CONFIG = 2'd1,
        ST_XFER   = 2'd2
    } xfer_state_e;

    localparam int SB_ALM  = 0;
    localparam int SB_OVF  = 1;
    localparam int SB_SYNC = 2;
    localparam int SB_CFG  = 3;
    localparam int SB_WOFF = 4;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRE_W     = 20,
    parameter int PRE_RESET = 32'h7FFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_ce,
    input  logic             load,
    input  logic [PRE_W-1:0] load_val,
    output logic             tick
);
    logic [PRE_W-1:0] reload_q;
    logic [PRE_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= PRE_W'(PRE_RESET);
            div_q    <= PRE_W'(PRE_RESET);
        end else if (load) begin
            reload_q <= load_val;
            div_q    <= load_val;
        end else if (slow_ce) begin
            if (div_q == '0) div_q <= reload_q;
            else             div_q <= div_q - PRE_W'(1);
        end
    end

    assign tick = slow_ce && !load && (div_q == '0);
endmodule

// File: rtl/rtc_xfer_fsm.sv
module rtc_xfer_fsm
    import rtc_pkg::*;
#(
    parameter int XFER_PULSES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_ce,
    input  logic        cfg_wr,
    input  logic        cfg_val,
    output logic        in_cfg,
    output logic        enter,
    output logic        apply,
    output logic        woff
);
    localparam int PW = $clog2(XFER_PULSES + 1);
    localparam logic [PW-1:0] LAST = PW'(XFER_PULSES - 1);

    xfer_state_e state_q, state_d;
    logic [PW-1:0] pcnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cfg_wr && cfg_val)        state_d = ST_CONFIG;
            ST_CONFIG: if (cfg_wr && !cfg_val)       state_d = ST_XFER;
            ST_XFER:   if (slow_ce && pcnt_q == LAST) state_d = ST_IDLE;
            default:                                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q != ST_XFER)  pcnt_q <= '0;
            else if (slow_ce)        pcnt_q <= pcnt_q + PW'(1);
        end
    end

    always_comb begin
        in_cfg = (state_q == ST_CONFIG);
        enter  = (state_q == ST_IDLE) && (state_d == ST_CONFIG);
        apply  = (state_q == ST_XFER) && (state_d == ST_IDLE);
        woff   = (state_q != ST_XFER);
    end

    AST_XFER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |-> (pcnt_q < PW'(XFER_PULSES))); // R4
    AST_WOFF_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(woff) |-> $past(slow_ce)); // R4
    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |=> (state_q != ST_CONFIG)); // R11
endmodule

// File: rtl/rtc_lp_top.sv
module rtc_lp_top
    import rtc_pkg::*;
#(
    parameter int PRE_W       = 20,
    parameter int PRE_RESET   = 32'h7FFF,
    parameter int XFER_PULSES = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_ce,
    input  logic [2:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq
);
    localparam int PRE_HI = PRE_W - BUS_W;
    localparam int HALF   = CNT_W / 2;

    logic in_cfg, enter, apply, woff, tick;
    logic cfg_wr;
    logic [CNT_W-1:0] cnt_q, alm_q, shadow_q, stg_cnt, stg_alm;
    logic [PRE_W-1:0] pre_q, stg_pre;
    logic d_cnt, d_alm, d_pre;
    logic alm_f, ovf_f, sync_f, refresh_q;
    logic [1:0] ie_q;
    logic cnt_apply, alm_apply, pre_apply;
    logic stat_wr, alm_hit, ovf_hit;

    assign cfg_wr  = bus_wr && (bus_addr == RA_STAT);
    assign stat_wr = cfg_wr;

    rtc_xfer_fsm #(.XFER_PULSES(XFER_PULSES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce),
        .cfg_wr(cfg_wr), .cfg_val(bus_wdata[SB_CFG]),
        .in_cfg(in_cfg), .enter(enter), .apply(apply), .woff(woff)
    );

    assign cnt_apply = apply && d_cnt;
    assign alm_apply = apply && d_alm;
    assign pre_apply = apply && d_pre;

    rtc_prescaler #(.PRE_W(PRE_W), .PRE_RESET(PRE_RESET)) u_pre (
        .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce),
        .load(pre_apply), .load_val(stg_pre), .tick(tick)
    );

    // staging copies, open only inside the configuration window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_cnt <= '0;
            stg_alm <= '1;
            stg_pre <= PRE_W'(PRE_RESET);
            d_cnt   <= 1'b0;
            d_alm   <= 1'b0;
            d_pre   <= 1'b0;
        end else if (enter) begin
            stg_cnt <= cnt_q;
            stg_alm <= alm_q;
            stg_pre <= pre_q;
            d_cnt   <= 1'b0;
            d_alm   <= 1'b0;
            d_pre   <= 1'b0;
        end else if (in_cfg && bus_wr) begin
            unique case (bus_addr)
                RA_PRE_UP: begin stg_pre[PRE_W-1:BUS_W] <= bus_wdata[PRE_HI-1:0]; d_pre <= 1'b1; end
                RA_PRE_LO: begin stg_pre[BUS_W-1:0]     <= bus_wdata;             d_pre <= 1'b1; end
                RA_CNT_UP: begin stg_cnt[CNT_W-1:HALF]  <= bus_wdata;             d_cnt <= 1'b1; end
                RA_CNT_LO: begin stg_cnt[HALF-1:0]      <= bus_wdata;             d_cnt <= 1'b1; end
                RA_ALM_UP: begin stg_alm[CNT_W-1:HALF]  <= bus_wdata;             d_alm <= 1'b1; end
                RA_ALM_LO: begin stg_alm[HALF-1:0]      <= bus_wdata;             d_alm <= 1'b1; end
                default: ;
            endcase
        end
    end

    // slow-domain values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            alm_q <= '1;
            pre_q <= PRE_W'(PRE_RESET);
        end else begin
            if (cnt_apply)  cnt_q <= stg_cnt;
            else if (tick)  cnt_q <= cnt_q + CNT_W'(1);
            if (alm_apply)  alm_q <= stg_alm;
            if (pre_apply)  pre_q <= stg_pre;
        end
    end

    assign ovf_hit = tick && !cnt_apply && (cnt_q == '1);
    assign alm_hit = tick && !cnt_apply && !alm_apply && (alm_q != '1)
                     && ((cnt_q + CNT_W'(1)) == alm_q);

    // flags, shadow and enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_f     <= 1'b0;
            ovf_f     <= 1'b0;
            sync_f    <= 1'b0;
            refresh_q <= 1'b0;
            shadow_q  <= '0;
            ie_q      <= '0;
        end else begin
            refresh_q <= slow_ce;
            if (refresh_q) shadow_q <= cnt_q;
            if (alm_hit)                             alm_f <= 1'b1;
            else if (stat_wr && !bus_wdata[SB_ALM])  alm_f <= 1'b0;
            if (ovf_hit)                             ovf_f <= 1'b1;
            else if (stat_wr && !bus_wdata[SB_OVF])  ovf_f <= 1'b0;
            if (refresh_q)                           sync_f <= 1'b1;
            else if (stat_wr && !bus_wdata[SB_SYNC]) sync_f <= 1'b0;
            if (bus_wr && bus_addr == RA_IE)         ie_q <= bus_wdata[1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            RA_STAT: begin
                bus_rdata[SB_ALM]  = alm_f;
                bus_rdata[SB_OVF]  = ovf_f;
                bus_rdata[SB_SYNC] = sync_f;
                bus_rdata[SB_CFG]  = in_cfg;
                bus_rdata[SB_WOFF] = woff;
            end
            RA_IE:     bus_rdata[1:0] = ie_q;
            RA_CNT_UP: bus_rdata = shadow_q[CNT_W-1:HALF];
            RA_CNT_LO: bus_rdata = shadow_q[HALF-1:0];
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = (alm_f && ie_q[0]) || (ovf_f && ie_q[1]);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_apply) |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R2
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_apply) |=> $stable(cnt_q)); // R3
    AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_f) |-> (cnt_q == '0)); // R7
    AST_ALARM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_f) |-> (cnt_q == alm_q && alm_q != '1)); // R8
    AST_SYNC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_q |=> sync_f); // R6
    AST_STAGE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_cfg && !enter) |=> $stable(stg_cnt)); // R3
endmodule

// File: tb/sim_rtc_lp_top.sv
module sim_rtc_lp_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_ce = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_lp_top u0 (
        .clk(clk), .rst_n(rst_n), .slow_ce(slow_ce),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic bw(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic br(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_cnt(output logic [31:0] v);
        logic [15:0] h, l;
        br(3'd4, h);
        br(3'd5, l);
        v = {h, l};
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) slow_ce = 1'b1;
            @(negedge clk) slow_ce = 1'b0;
            @(negedge clk);
        end
    endtask

    // open window, stage everything, commit, run the three transfer pulses
    task automatic cfg_all(input logic [31:0] pre, input logic [31:0] c, input logic [31:0] al);
        bw(3'd0, 16'h000F);
        bw(3'd2, pre[31:16]); bw(3'd3, pre[15:0]);
        bw(3'd4, c[31:16]);   bw(3'd5, c[15:0]);
        bw(3'd6, al[31:16]);  bw(3'd7, al[15:0]);
        bw(3'd0, 16'h0007);
        pulses(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog got=running exp=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        logic [31:0] v, e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        br(3'd0, r); chk("R1 status", r, 32'h0010);
        br(3'd1, r); chk("R1 ie", r, 0);
        rd_cnt(v);   chk("R1 count", v, 0);
        chk("R1 irq", irq, 0);

        // R3 writes outside window ignored
        bw(3'd5, 16'h1234); bw(3'd4, 16'h5678);
        pulses(1);
        rd_cnt(v); chk("R3 count untouched", v, 0);

        // R4/R11 transfer, scenario with overflow and alarm, reload 1
        bw(3'd0, 16'h000F);
        bw(3'd2, 16'h0); bw(3'd3, 16'h0001);
        bw(3'd4, 16'hFFFF); bw(3'd5, 16'hFFFC);
        bw(3'd6, 16'h0000); bw(3'd7, 16'h0002);
        bw(3'd0, 16'h0007);
        br(3'd0, r); chk("R4 woff low after commit", r[4], 0);
        bw(3'd0, 16'h000F);
        br(3'd0, r); chk("R11 cfg entry ignored", r[3], 0);
        pulses(2);
        br(3'd0, r); chk("R4 woff low after 2", r[4], 0);
        rd_cnt(v); chk("R4 count old", v, 0);
        pulses(1);
        br(3'd0, r); chk("R4 woff high after 3", r[4], 1);
        rd_cnt(v); chk("R4 count applied", v, 32'hFFFF_FFFC);
        for (int k = 1; k <= 12; k++) begin
            pulses(1);
            e = 32'hFFFF_FFFC + 32'(k / 2);
            rd_cnt(v); chk("R2 count step", v, e);
            br(3'd0, r);
            chk("R7 overflow flag", r[1], (k / 2) >= 4);
            chk("R8 alarm flag", r[0], (k / 2) >= 6);
            chk("R8 irq masked", irq, 0);
        end
        bw(3'd1, 16'h0001); chk("R8 irq alarm en", irq, 1);
        bw(3'd0, 16'h0006);
        br(3'd0, r); chk("R9 alarm cleared", r[1:0], 2'b10);
        chk("R8 irq after clear", irq, 0);
        bw(3'd1, 16'h0002); chk("R8 irq ovf en", irq, 1);
        bw(3'd0, 16'h0005);
        br(3'd0, r); chk("R9 ovf cleared", r[1:0], 2'b00);
        chk("R9 irq low", irq, 0);
        bw(3'd1, 16'h0000);

        // R2 prescaler sweep
        for (int rl = 0; rl < 4; rl++) begin
            cfg_all(32'(rl), 32'h0, 32'hFFFF_FFFF);
            pulses(12);
            rd_cnt(v); chk("R2 prescale sweep", v, 32'(12 / (rl + 1)));
        end

        // R10 all-ones alarm never fires
        cfg_all(32'h0, 32'hFFFF_FFFD, 32'hFFFF_FFFF);
        bw(3'd0, 16'h0004);
        pulses(4);
        rd_cnt(v); chk("R10 count wrapped", v, 32'h1);
        br(3'd0, r); chk("R10 no alarm, ovf set", r[1:0], 2'b10);

        // R5 half write, prescaler kept
        cfg_all(32'hF_FFFF, 32'hABCD_0000, 32'hFFFF_FFFF);
        bw(3'd0, 16'h000F);
        bw(3'd5, 16'h0005);
        bw(3'd0, 16'h0007);
        pulses(3);
        rd_cnt(v); chk("R5 half keeps high", v, 32'hABCD_0005);
        pulses(4);
        rd_cnt(v); chk("R5 prescaler kept", v, 32'hABCD_0005);

        // R6 sync flag
        bw(3'd0, 16'h0003);
        br(3'd0, r); chk("R6 sync cleared", r[2], 0);
        bw(3'd0, 16'h0007);
        br(3'd0, r); chk("R6 write one no effect", r[2], 0);
        pulses(1);
        br(3'd0, r); chk("R6 sync set", r[2], 1);

        // R12 reads
        br(3'd2, r); chk("R12 pre reads 0", r, 0);
        br(3'd7, r); chk("R12 alarm reads 0", r, 0);
        begin
            logic [15:0] l1, h1, l2;
            br(3'd5, l1); br(3'd4, h1); br(3'd5, l2);
            chk("R12 coherent low", l2, l1);
            chk("R12 coherent value", {h1, l2}, 32'hABCD_0005);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule